// File: doc/BRIEF.md
# Adaptive-Threshold Line Period Detector

The block takes a stream of rectified line-voltage samples and works out where each AC half cycle begins and ends. It derives a threshold from the largest sample of the previous half cycle. It confirms an upward pass and then a downward pass through that threshold, each with hysteresis and a programmable run length. The midpoint of the two passes is taken as the zero-crossing instant. The distance between two successive instants is the half period, counted in samples. The block reports it together with a one-cycle valid pulse and a boundary strobe, which marks the end of a half cycle for the RMS accumulators downstream.

A DC input, or a waveform that stays below the threshold, produces no crossings. In that case the block inserts a boundary of its own once a programmed maximum period has passed, reports that period, and raises a DC flag, so that downstream measurements keep running. The flag drops on the second real zero crossing that follows.

Top module: `line_period_det`

## Requirements
- R1: The threshold is the larger of the previous half cycle's peak divided by 2 (shift right by one) and `thr_floor_i`. The hysteresis is that peak shifted right by 4. A sample counts toward an upward pass when it is strictly greater than threshold plus hysteresis. It counts toward a downward pass when it is strictly less than threshold minus hysteresis. With a floor above every sample, no crossing is ever found.
- R2: A pass is accepted on the sample that completes an unbroken run of N qualifying samples, where N = `confirm_i`, and a value of 0 is treated as 1. Any non-qualifying sample restarts the run, so a run shorter than N has no effect on the outputs. The detector alternates: an upward pass first, then a downward pass.
- R3: Samples are numbered by a 24-bit counter that advances once per `smp_vld_i`. The zero-crossing instant is t_up + ((t_down - t_up) >> 1) modulo 2^24, where t_up and t_down are the numbers of the accepting samples.
- R4: On each zero crossing that has an earlier real crossing to refer to, `half_period_o` takes the difference of the two instants (modulo 2^24) and `period_vld_o` pulses for one clock. Between updates, `half_period_o` holds its value.
- R5: `boundary_o` pulses for one clock, on the clock after the accepting sample, for every zero crossing and every inserted boundary.
- R6: If `max_period_i` samples in a row pass since the last boundary with no zero crossing, the last of them produces an inserted boundary. That boundary loads `half_period_o` with `max_period_i`, pulses `period_vld_o`, and sets `dc_mode_o`. A real crossing on the same sample takes precedence, and `max_period_i` = 0 disables insertion.
- R7: The first real zero crossing after reset or after an inserted boundary pulses `boundary_o` without `period_vld_o`. While `dc_mode_o` is set, it clears on the second real zero crossing after the inserted boundary, in the same clock as that crossing's `period_vld_o`.
- R8: After reset, all outputs are 0, and the detector waits for an upward pass.
- R9: Each boundary stores, as the new previous peak, the largest sample since the last boundary, including the boundary sample itself. The stored peak sets the threshold for the half cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | A new sample is present on `smp_i` |
| smp_i | input | 16 | Rectified line-voltage sample, unsigned |
| thr_floor_i | input | 16 | Minimum threshold |
| confirm_i | input | 4 | Qualifying run length (0 acts as 1) |
| max_period_i | input | 24 | Fallback period in samples (0 disables it) |
| half_period_o | output | 24 | Last half period in samples |
| period_vld_o | output | 1 | One-clock pulse when `half_period_o` updates |
| boundary_o | output | 1 | One-clock half-cycle boundary strobe |
| dc_mode_o | output | 1 | Set while running on the fallback period |

## Verification
Clean triangular humps of constant width check that the reported half period equals the hump width exactly. Square humps with alternating widths and gaps give a different period for each midpoint rule, so they expose an endpoint used in place of the midpoint. A floor above the signal, followed by a return to a normal waveform, exercises the inserted boundaries, the DC flag and the two-crossing recovery. Plateaus with dips one sample shorter than the run length, and exactly equal to it, separate ignored glitches from accepted passes. Random segments of noisy humps, flat DC levels and near-zero input, with random run lengths including 0, are compared sample by sample against a reference model.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  typedef enum logic {SEEK_RISE = 1'b0, SEEK_FALL = 1'b1} xing_st_e;
endpackage

// File: rtl/lpd_thresh.sv
module lpd_thresh #(
  parameter int SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_vld_i,
  input  logic [SW-1:0] smp_i,
  input  logic          bnd_i,
  input  logic [SW-1:0] floor_i,
  output logic [SW:0]   thr_hi_o,
  output logic [SW-1:0] thr_lo_o
);
  logic [SW-1:0] pk_cur_q, pk_prev_q, pk_next, half_pk, thr, hyst;

  assign pk_next  = (smp_i > pk_cur_q) ? smp_i : pk_cur_q;
  assign half_pk  = pk_prev_q >> 1;
  assign thr      = (half_pk > floor_i) ? half_pk : floor_i;
  assign hyst     = pk_prev_q >> 4;
  assign thr_hi_o = {1'b0, thr} + {1'b0, hyst};
  // thr >= peak/2 >= peak/16, so no underflow
  assign thr_lo_o = thr - hyst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pk_cur_q  <= '0;
      pk_prev_q <= '0;
    end else if (smp_vld_i) begin
      if (bnd_i) begin
        pk_prev_q <= pk_next;
        pk_cur_q  <= '0;
      end else begin
        pk_cur_q  <= pk_next;
      end
    end
  end

  AST_PEAK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && bnd_i) |=> (pk_cur_q == '0)); // R9
  AST_PEAK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> ($stable(pk_prev_q) && $stable(pk_cur_q))); // R9
  AST_PEAK_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && !bnd_i) |=> (pk_cur_q >= $past(smp_i))); // R9
endmodule

// File: rtl/lpd_xing.sv
module lpd_xing
  import lpd_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_vld_i,
  input  logic [SW-1:0] smp_i,
  input  logic [SW:0]   thr_hi_i,
  input  logic [SW-1:0] thr_lo_i,
  input  logic [CW-1:0] confirm_i,
  output logic          rise_o,
  output logic          fall_o
);
  xing_st_e     st_q;
  logic [CW-1:0] run_q;
  logic [CW:0]   need, run_inc;
  logic          qual, hit;

  assign need    = (confirm_i == '0) ? (CW+1)'(1) : {1'b0, confirm_i};
  assign run_inc = {1'b0, run_q} + (CW+1)'(1);
  assign qual    = (st_q == SEEK_RISE) ? ({1'b0, smp_i} > thr_hi_i)
                                       : (smp_i < thr_lo_i);
  assign hit     = smp_vld_i && qual && (run_inc == need);
  assign rise_o  = hit && (st_q == SEEK_RISE);
  assign fall_o  = hit && (st_q == SEEK_FALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEEK_RISE;
      run_q <= '0;
    end else if (smp_vld_i) begin
      if (!qual) begin
        run_q <= '0;
      end else if (hit) begin
        run_q <= '0;
        st_q  <= (st_q == SEEK_RISE) ? SEEK_FALL : SEEK_RISE;
      end else begin
        run_q <= run_inc[CW-1:0];
      end
    end
  end

  AST_ACC_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |-> smp_vld_i); // R2
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> ($stable(run_q) && $stable(st_q))); // R2
  AST_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/lpd_period.sv
module lpd_period #(
  parameter int TW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_vld_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [TW-1:0] max_period_i,
  output logic          bnd_o,
  output logic [TW-1:0] half_period_o,
  output logic          period_vld_o,
  output logic          boundary_o,
  output logic          dc_mode_o
);
  logic [TW-1:0] ts_q, t_rise_q, zc_prev_q, since_q, zc_now;
  logic          have_zc_q, real_seen_q, real_zc, syn_zc;

  assign zc_now  = t_rise_q + ((ts_q - t_rise_q) >> 1);
  assign real_zc = smp_vld_i && fall_i;
  assign syn_zc  = smp_vld_i && !fall_i && (max_period_i != '0) &&
                   (({1'b0, since_q} + (TW+1)'(1)) == {1'b0, max_period_i});
  assign bnd_o   = real_zc || syn_zc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q          <= '0;
      t_rise_q      <= '0;
      zc_prev_q     <= '0;
      since_q       <= '0;
      have_zc_q     <= 1'b0;
      real_seen_q   <= 1'b0;
      half_period_o <= '0;
      period_vld_o  <= 1'b0;
      boundary_o    <= 1'b0;
      dc_mode_o     <= 1'b0;
    end else begin
      period_vld_o <= 1'b0;
      boundary_o   <= 1'b0;
      if (smp_vld_i) begin
        ts_q <= ts_q + 1'b1;
        if (rise_i) t_rise_q <= ts_q;
        if (real_zc) begin
          zc_prev_q  <= zc_now;
          have_zc_q  <= 1'b1;
          since_q    <= '0;
          boundary_o <= 1'b1;
          if (have_zc_q) begin
            half_period_o <= zc_now - zc_prev_q;
            period_vld_o  <= 1'b1;
          end
          if (dc_mode_o) begin
            if (real_seen_q) begin
              dc_mode_o   <= 1'b0;
              real_seen_q <= 1'b0;
            end else begin
              real_seen_q <= 1'b1;
            end
          end
        end else if (syn_zc) begin
          since_q       <= '0;
          have_zc_q     <= 1'b0;
          real_seen_q   <= 1'b0;
          boundary_o    <= 1'b1;
          half_period_o <= max_period_i;
          period_vld_o  <= 1'b1;
          dc_mode_o     <= 1'b1;
        end else begin
          since_q <= since_q + 1'b1;
        end
      end
    end
  end

  AST_PV_BND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_vld_o |-> boundary_o); // R4
  AST_DC_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dc_mode_o) |-> (period_vld_o && (half_period_o == $past(max_period_i)))); // R6
  AST_DC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dc_mode_o) |-> (period_vld_o && boundary_o)); // R7
  AST_TS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> ($stable(ts_q) && !boundary_o)); // R5
  AST_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_vld_o |-> $stable(half_period_o)); // R4
endmodule

// File: rtl/line_period_det.sv
module line_period_det #(
  parameter int SMP_W  = 16,
  parameter int TS_W   = 24,
  parameter int CONF_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [SMP_W-1:0]  thr_floor_i,
  input  logic [CONF_W-1:0] confirm_i,
  input  logic [TS_W-1:0]   max_period_i,
  output logic [TS_W-1:0]   half_period_o,
  output logic              period_vld_o,
  output logic              boundary_o,
  output logic              dc_mode_o
);
  logic [SMP_W:0]   thr_hi;
  logic [SMP_W-1:0] thr_lo;
  logic             rise, fall, bnd;

  lpd_thresh #(.SW(SMP_W)) u_thresh (
    .clk_i, .rst_ni, .smp_vld_i, .smp_i,
    .bnd_i(bnd), .floor_i(thr_floor_i),
    .thr_hi_o(thr_hi), .thr_lo_o(thr_lo)
  );

  lpd_xing #(.SW(SMP_W), .CW(CONF_W)) u_xing (
    .clk_i, .rst_ni, .smp_vld_i, .smp_i,
    .thr_hi_i(thr_hi), .thr_lo_i(thr_lo), .confirm_i,
    .rise_o(rise), .fall_o(fall)
  );

  lpd_period #(.TW(TS_W)) u_period (
    .clk_i, .rst_ni, .smp_vld_i,
    .rise_i(rise), .fall_i(fall), .max_period_i,
    .bnd_o(bnd), .half_period_o, .period_vld_o, .boundary_o, .dc_mode_o
  );
endmodule

// File: tb/tb_line_period_det.sv
`timescale 1ns/1ps
module tb_line_period_det;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] smp = '0;
  logic [15:0] floor_v = 16'd100;
  logic [3:0]  conf = 4'd3;
  logic [23:0] maxp = 24'd150;
  logic [23:0] half;
  logic        pv, bnd, dc;

  always #2.5 clk = ~clk;

  line_period_det dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_i(smp),
    .thr_floor_i(floor_v), .confirm_i(conf), .max_period_i(maxp),
    .half_period_o(half), .period_vld_o(pv), .boundary_o(bnd), .dc_mode_o(dc)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_fall;
  int          m_run, m_pc, m_pp;
  logic [23:0] m_ts, m_tr, m_zp, m_since, e_half;
  bit          m_have, m_dc, m_seen, e_bnd, e_pv;

  // observations
  int          obs_bnd;
  logic [23:0] last_half;
  bit          rec;
  int          ev_n;
  bit          ev_pv[4], ev_dc[4];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int tri_v(int p, int h, int a);
    int d = (p < h - p) ? p : h - p;
    return a * d * 2 / h;
  endfunction

  task automatic m_step(input int s);
    int thr, hy, hi, lo, need;
    bit qual, acc, rise, fall, syn;
    logic [23:0] zc;
    thr  = imax(m_pp >> 1, int'(floor_v));
    hy   = m_pp >> 4;
    hi   = thr + hy;
    lo   = thr - hy;
    need = (conf == 0) ? 1 : int'(conf);
    qual = m_fall ? (s < lo) : (s > hi);
    acc  = qual && (m_run + 1 == need);
    rise = acc && !m_fall;
    fall = acc && m_fall;
    zc   = m_tr + ((m_ts - m_tr) >> 1);
    syn  = !fall && (maxp != 0) && (int'(m_since) + 1 == int'(maxp));
    e_bnd = 1'b0; e_pv = 1'b0;
    if (fall || syn) begin m_pp = imax(m_pc, s); m_pc = 0; end
    else m_pc = imax(m_pc, s);
    if (!qual) m_run = 0;
    else if (acc) begin m_run = 0; m_fall = !m_fall; end
    else m_run++;
    if (rise) m_tr = m_ts;
    if (fall) begin
      e_bnd = 1'b1; m_since = '0;
      if (m_have) begin e_half = zc - m_zp; e_pv = 1'b1; end
      m_zp = zc; m_have = 1'b1;
      if (m_dc) begin
        if (m_seen) begin m_dc = 1'b0; m_seen = 1'b0; end
        else m_seen = 1'b1;
      end
    end else if (syn) begin
      e_bnd = 1'b1; e_pv = 1'b1; e_half = maxp; m_dc = 1'b1;
      m_have = 1'b0; m_seen = 1'b0; m_since = '0;
    end else m_since = m_since + 1'b1;
    m_ts = m_ts + 1'b1;
  endtask

  task automatic apply(input int s_in);
    int s = (s_in < 0) ? 0 : (s_in > 65535 ? 65535 : s_in);
    m_step(s);
    @(negedge clk); smp = 16'(s); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
    chk(bnd == e_bnd, "R5 boundary strobe", bnd, e_bnd);
    chk(pv == e_pv, "R4 period valid", pv, e_pv);
    chk(half == e_half, "R4 half period", half, e_half);
    chk(dc == m_dc, "R6 dc flag", dc, m_dc);
    if (bnd) begin
      obs_bnd++;
      if (rec && ev_n < 4) begin ev_pv[ev_n] = pv; ev_dc[ev_n] = dc; ev_n++; end
    end
    if (pv) last_half = half;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base, kind, h, a, k, humps, lvl;
    void'($urandom(32'h1f2e3d4c));
    m_fall = 0; m_run = 0; m_pc = 0; m_pp = 0;
    m_ts = '0; m_tr = '0; m_zp = '0; m_since = '0; e_half = '0;
    m_have = 0; m_dc = 0; m_seen = 0;
    obs_bnd = 0; last_half = '0; rec = 0; ev_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk({half, pv, bnd, dc} == '0, "R8 outputs after reset", {half, pv, bnd, dc}, 0);

    // R1 / R6: floor above the signal, only inserted boundaries
    floor_v = 16'd2000; maxp = 24'd150; conf = 4'd3;
    base = obs_bnd;
    for (int i = 0; i < 600; i++) apply(tri_v(i % 60, 60, 1000));
    chk(obs_bnd - base == 4, "R1 no crossing above floor", obs_bnd - base, 4);
    chk(last_half == 150, "R6 inserted period", last_half, 150);
    chk(dc == 1'b1, "R6 dc flag set", dc, 1);

    // R7: recovery from dc mode
    floor_v = 16'd100; rec = 1; ev_n = 0;
    for (int j = 0; j < 4; j++)
      for (int p = 0; p < 60; p++) apply(tri_v(p, 60, 1000));
    rec = 0;
    chk(ev_n >= 2, "R7 recovery boundaries seen", ev_n, 2);
    chk(ev_pv[0] == 1'b0 && ev_dc[0] == 1'b1, "R7 first real crossing", {ev_pv[0], ev_dc[0]}, 1);
    chk(ev_pv[1] == 1'b1 && ev_dc[1] == 1'b0, "R7 second real crossing", {ev_pv[1], ev_dc[1]}, 2);

    // R3: clean humps of width 60
    for (int j = 0; j < 8; j++)
      for (int p = 0; p < 60; p++) apply(tri_v(p, 60, 1000));
    chk(last_half == 60, "R3 constant hump spacing", last_half, 60);

    // R3: square humps, unequal widths and gaps -> 60 then 80
    for (int j = 0; j < 3; j++) begin
      repeat (20) apply(1000); repeat (30) apply(0);
      if (j == 2) chk(last_half == 80, "R3 midpoint after short hump", last_half, 80);
      repeat (40) apply(1000); repeat (50) apply(0);
      if (j == 2) chk(last_half == 60, "R3 midpoint after long hump", last_half, 60);
    end

    // R2: dip shorter than the run length is ignored
    conf = 4'd3; base = obs_bnd;
    repeat (30) apply(1000); repeat (2) apply(0); repeat (30) apply(1000); repeat (30) apply(0);
    chk(obs_bnd - base == 1, "R2 short dip ignored", obs_bnd - base, 1);
    base = obs_bnd;
    repeat (30) apply(1000); repeat (3) apply(0); repeat (30) apply(1000); repeat (30) apply(0);
    chk(obs_bnd - base == 2, "R2 full-length dip accepted", obs_bnd - base, 2);

    // random segments against the model (R9 peak tracking covered here)
    for (int seg = 0; seg < 24; seg++) begin
      kind    = $urandom_range(9, 0);
      conf    = 4'($urandom_range(4, 0));
      floor_v = 16'($urandom_range(300, 50));
      maxp    = 24'd260;
      if (kind == 0) begin
        lvl = $urandom_range(20000, 200);
        k = lvl / 64 + 1;
        repeat (400) apply(lvl + int'($urandom_range(2 * k, 0)) - k);
      end else if (kind == 1) begin
        repeat (300) apply($urandom_range(20, 0));
      end else begin
        h = $urandom_range(120, 40);
        a = $urandom_range(30000, 1000);
        k = a / 64 + 1;
        humps = $urandom_range(8, 4);
        for (int j = 0; j < humps; j++)
          for (int p = 0; p < h; p++)
            apply(tri_v(p, h, a) + int'($urandom_range(2 * k, 0)) - k);
      end
    end
    chk(obs_bnd > 50, "R9 boundaries over random run", obs_bnd, 50);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule